// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year, and a weekday index. It advances by one second on each cycle in which the `tick` input is high, usually driven by a 1 Hz enable derived elsewhere. Carries run from seconds up to the year, and the day count follows the length of the current month, including leap Februaries.

Software reaches the block through a byte-wide register port with one address, write data, a write strobe and registered read data. To set the clock, software clears the run bit, writes the time bytes, then sets the run bit again. To read a consistent multi-byte time while the clock runs, software fires a snapshot strobe. This copies all live counters into a shadow bank in one cycle. Software then sets the shadow-select bit so that reads of the time addresses return the frozen copy.

A control bit picks 12-hour display, in which the hour byte carries an afternoon flag. Another control strobe rounds the time to the nearest minute.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After synchronous reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control and status registers read 0x00.
- R2: Seconds and minutes count 0x00..0x59 in BCD. Wrapping 0x59 to 0x00 carries into the next field. In 24-hour mode, hours wrap from 0x23 to 0x00 and carry into the day.
- R3: The day wraps to 0x01 after the last day of the current month. February has 29 days when the BCD year is divisible by 4. Month wraps 0x12 to 0x01 and carries into the year. Year wraps 0x99 to 0x00. The weekday (address 0x06) counts 0x00..0x06 and advances with each day carry.
- R4: Control bit 0 (address 0x08) is the run bit. While it is 0, `tick` is ignored and the time does not change. Status bit 1 (address 0x09) reads 1 exactly while the run bit is 1.
- R5: A write to address 0x00..0x06 (seconds, minutes, hours, day, month, year, weekday in that order) loads that byte. A tick in the same cycle is dropped.
- R6: Writing 1 to control bit 6 copies all seven live time bytes, as they stood before that clock edge, into the shadow bank. Control bit 6 always reads back 0.
- R7: While control bit 7 is 1, reads of addresses 0x00..0x06 return the shadow bank. While it is 0, they return the live counters.
- R8: With control bit 3 set (12-hour mode), the hour byte holds BCD 0x01..0x12 in bits 5:0 and the afternoon flag in bit 7. An advance from 11 to 12 toggles the flag. An advance from 12 goes to 01. Moving from 11 with the flag set to 12 with the flag clear carries into the day.
- R9: Writing 1 to control bit 1 sets seconds to 0x00. If seconds were 0x30 or more, it also advances the minute with a full carry chain. A tick in that cycle is dropped, and bit 1 always reads back 0.
- R10: Read data is registered and reflects the address presented one clock earlier. Control reads back bits 7, 3 and 0 as written. Status has only bit 1. All other addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable, one cycle per second |
| addr | input | ADDR_W | Register address for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous cycle's address |

## Verification
The in-line assertions watch, on every cycle, that the counters hold while stopped, that seconds and the year wrap to zero, and that the afternoon flag flips on an 11-to-12 step. They also check that the round strobe clears seconds, that a snapshot copies the prior live bytes exactly, and that the two control strobes read back as zero.

Month lengths, leap Februaries, the full carry chain from seconds to year, and the shadow versus live read selection can only be shown by the bench's scenarios. The same holds for the tick being dropped on a load cycle and for rounding below and above half a minute. In each of these scenarios a behavioural calendar model predicts the registered read data cycle by cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  localparam int IDX_YEAR = 5;
  localparam int IDX_WDAY = 6;

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_ROUND = 1;
  localparam int CTRL_12H   = 3;
  localparam int CTRL_SNAP  = 6;
  localparam int CTRL_SHSEL = 7;
  localparam int STAT_RUN   = 1;

  typedef logic [BYTE_W-1:0] bcd8_t;

  typedef struct packed {
    logic  wrap;
    bcd8_t val;
  } bcd_step_t;

  function automatic bcd8_t field_reset(int idx);
    return (idx == IDX_DAY || idx == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

  // One BCD increment; at or beyond the top value it wraps to the bottom value.
  function automatic bcd_step_t bcd_step(bcd8_t v, bcd8_t lo, bcd8_t hi);
    bcd_step_t r;
    if (v >= hi) begin
      r.wrap = 1'b1;
      r.val  = lo;
    end else if (v[3:0] >= 4'd9) begin
      r.wrap = 1'b0;
      r.val  = {v[7:4] + 4'd1, 4'd0};
    end else begin
      r.wrap = 1'b0;
      r.val  = {v[7:4], v[3:0] + 4'd1};
    end
    return r;
  endfunction

  // 12-hour step: bit 7 is the afternoon flag, bits 5:0 the BCD hour 01..12.
  function automatic bcd_step_t hour12_step(bcd8_t v);
    bcd_step_t r;
    bcd_step_t inner;
    logic      pm;
    pm    = v[7];
    inner = bcd_step({2'b00, v[5:0]}, 8'h01, 8'h12);
    if (v[5:0] == 6'h11) begin
      r.val  = {~pm, 1'b0, 6'h12};
      r.wrap = pm;
    end else if (v[5:0] >= 6'h12) begin
      r.val  = {pm, 1'b0, 6'h01};
      r.wrap = 1'b0;
    end else begin
      r.val  = {pm, 1'b0, inner.val[5:0]};
      r.wrap = 1'b0;
    end
    return r;
  endfunction

  function automatic logic leap_year(bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t month_last(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter int N_FIELDS = NUM_FIELDS,
  localparam int SW = $clog2(N_FIELDS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            run_i,
  input  logic                            mode12_i,
  input  logic                            tick_i,
  input  logic                            round_i,
  input  logic                            ld_en_i,
  input  logic [SW-1:0]                   ld_sel_i,
  input  logic [BYTE_W-1:0]               ld_data_i,
  output logic [N_FIELDS-1:0][BYTE_W-1:0] fields_o
);
  bcd8_t     nxt [N_FIELDS];
  bcd_step_t s_st, m_st, h24_st, h12_st, h_st, d_st, mo_st, y_st, w_st;
  logic      adv, round_up, c_min, c_hour, c_day, c_mon, c_year;

  assign adv      = tick_i & run_i & ~ld_en_i & ~round_i;
  assign round_up = round_i & (fields_o[IDX_SEC] >= 8'h30);

  always_comb begin
    s_st   = bcd_step(fields_o[IDX_SEC], 8'h00, 8'h59);
    m_st   = bcd_step(fields_o[IDX_MIN], 8'h00, 8'h59);
    h24_st = bcd_step(fields_o[IDX_HOUR], 8'h00, 8'h23);
    h12_st = hour12_step(fields_o[IDX_HOUR]);
    h_st   = mode12_i ? h12_st : h24_st;
    d_st   = bcd_step(fields_o[IDX_DAY], 8'h01,
                      month_last(fields_o[IDX_MON], fields_o[IDX_YEAR]));
    mo_st  = bcd_step(fields_o[IDX_MON], 8'h01, 8'h12);
    y_st   = bcd_step(fields_o[IDX_YEAR], 8'h00, 8'h99);
    w_st   = bcd_step(fields_o[IDX_WDAY], 8'h00, 8'h06);
  end

  assign c_min  = (adv & s_st.wrap) | round_up;
  assign c_hour = c_min & m_st.wrap;
  assign c_day  = c_hour & h_st.wrap;
  assign c_mon  = c_day & d_st.wrap;
  assign c_year = c_mon & mo_st.wrap;

  always_comb begin
    for (int i = 0; i < N_FIELDS; i++) nxt[i] = fields_o[i];
    if (round_i)  nxt[IDX_SEC]  = 8'h00;
    else if (adv) nxt[IDX_SEC]  = s_st.val;
    if (c_min)    nxt[IDX_MIN]  = m_st.val;
    if (c_hour)   nxt[IDX_HOUR] = h_st.val;
    if (c_day) begin
      nxt[IDX_DAY]  = d_st.val;
      nxt[IDX_WDAY] = w_st.val;
    end
    if (c_mon)    nxt[IDX_MON]  = mo_st.val;
    if (c_year)   nxt[IDX_YEAR] = y_st.val;
  end

  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_fld
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                      q <= field_reset(gi);
      else if (ld_en_i && ld_sel_i == SW'(gi))      q <= ld_data_i;
      else                                          q <= nxt[gi];
    end
    assign fields_o[gi] = q;
  end

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !ld_en_i && !round_i) |=> (fields_o == $past(fields_o)));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && fields_o[IDX_SEC] == 8'h59) |=> (fields_o[IDX_SEC] == 8'h00));

  assert_year_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (c_year && fields_o[IDX_YEAR] == 8'h99) |=> (fields_o[IDX_YEAR] == 8'h00));

  assert_pm_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (mode12_i && c_hour && fields_o[IDX_HOUR][5:0] == 6'h11)
      |=> (fields_o[IDX_HOUR][7] != $past(fields_o[IDX_HOUR][7])));

  assert_round_clears_R9: assert property (@(posedge clk) disable iff (rst)
    round_i |=> (fields_o[IDX_SEC] == 8'h00));
endmodule

// File: rtl/rtc_cal_shadow.sv
module rtc_cal_shadow
  import rtc_cal_pkg::*;
#(
  parameter int N_FIELDS = NUM_FIELDS
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            snap_i,
  input  logic [N_FIELDS-1:0][BYTE_W-1:0] live_i,
  output logic [N_FIELDS-1:0][BYTE_W-1:0] shadow_o
);
  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_sh
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)         q <= field_reset(gi);
      else if (snap_i) q <= live_i[gi];
    end
    assign shadow_o[gi] = q;
  end

  assert_snap_copy_R6: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> (shadow_o == $past(live_i)));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !snap_i |=> $stable(shadow_o));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h08,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h09
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data
);
  logic                              run_q, mode12_q, shsel_q;
  logic                              time_hit, ctrl_wr, snap, round;
  logic [SEL_W-1:0]                  sel;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] live, shadow;
  logic [BYTE_W-1:0]                 rd_next;

  assign time_hit = (addr < ADDR_W'(NUM_FIELDS));
  assign sel      = addr[SEL_W-1:0];
  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign snap     = ctrl_wr & wr_data[CTRL_SNAP];
  assign round    = ctrl_wr & wr_data[CTRL_ROUND];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      mode12_q <= 1'b0;
      shsel_q  <= 1'b0;
    end else if (ctrl_wr) begin
      run_q    <= wr_data[CTRL_RUN];
      mode12_q <= wr_data[CTRL_12H];
      shsel_q  <= wr_data[CTRL_SHSEL];
    end
  end

  rtc_cal_counter #(.N_FIELDS(NUM_FIELDS)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .run_i     (run_q),
    .mode12_i  (mode12_q),
    .tick_i    (tick),
    .round_i   (round),
    .ld_en_i   (wr_en && time_hit),
    .ld_sel_i  (sel),
    .ld_data_i (wr_data),
    .fields_o  (live)
  );

  rtc_cal_shadow #(.N_FIELDS(NUM_FIELDS)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .snap_i   (snap),
    .live_i   (live),
    .shadow_o (shadow)
  );

  always_comb begin
    rd_next = '0;
    if (time_hit) begin
      rd_next = shsel_q ? shadow[sel] : live[sel];
    end else if (addr == CTRL_ADDR) begin
      rd_next[CTRL_RUN]   = run_q;
      rd_next[CTRL_12H]   = mode12_q;
      rd_next[CTRL_SHSEL] = shsel_q;
    end else if (addr == STAT_ADDR) begin
      rd_next[STAT_RUN] = run_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assert_strobes_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == CTRL_ADDR) |-> (rd_data[CTRL_SNAP] == 1'b0 && rd_data[CTRL_ROUND] == 1'b0));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_calendar dut_i (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_f [7];
  bit [7:0] m_sh [7];
  bit       m_run, m_12, m_sel, primed;
  bit [7:0] exp_rd;

  function automatic int b2i(bit [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bit [7:0] i2b(int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void m_year_month_carry();
    if (b2i(m_f[4]) >= 12) begin
      m_f[4] = 8'h01;
      m_f[5] = (b2i(m_f[5]) >= 99) ? 8'h00 : i2b(b2i(m_f[5]) + 1);
    end else m_f[4] = i2b(b2i(m_f[4]) + 1);
  endfunction

  function automatic void m_day_carry();
    m_f[6] = (b2i(m_f[6]) >= 6) ? 8'h00 : i2b(b2i(m_f[6]) + 1);
    if (b2i(m_f[3]) >= days_in(b2i(m_f[4]), b2i(m_f[5]))) begin
      m_f[3] = 8'h01;
      m_year_month_carry();
    end else m_f[3] = i2b(b2i(m_f[3]) + 1);
  endfunction

  function automatic void m_hour_carry();
    if (m_12) begin
      int  h;
      bit  pm;
      h  = b2i({2'b00, m_f[2][5:0]});
      pm = m_f[2][7];
      if (h == 11) begin
        m_f[2] = {~pm, 7'h12};
        if (pm) m_day_carry();
      end else if (h >= 12) m_f[2] = {pm, 7'h01};
      else m_f[2] = {pm, 1'b0, i2b(h + 1)[5:0]};
    end else begin
      if (b2i(m_f[2]) >= 23) begin
        m_f[2] = 8'h00;
        m_day_carry();
      end else m_f[2] = i2b(b2i(m_f[2]) + 1);
    end
  endfunction

  function automatic void m_min_carry();
    if (b2i(m_f[1]) >= 59) begin
      m_f[1] = 8'h00;
      m_hour_carry();
    end else m_f[1] = i2b(b2i(m_f[1]) + 1);
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < 7; i++) begin
      m_f[i]  = (i == 3 || i == 4) ? 8'h01 : 8'h00;
      m_sh[i] = m_f[i];
    end
    m_run = 0; m_12 = 0; m_sel = 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reset();
      exp_rd = 8'h00;
      primed = 1;
    end else begin
      if (addr < 7)       exp_rd = m_sel ? m_sh[addr] : m_f[addr];
      else if (addr == 8) exp_rd = {m_sel, 3'b000, m_12, 2'b00, m_run};
      else if (addr == 9) exp_rd = {6'b0, m_run, 1'b0};
      else                exp_rd = 8'h00;
      if (wr_en && addr < 7) begin
        m_f[addr] = wr_data;
      end else begin
        bit ctl;
        ctl = wr_en && addr == 8;
        if (ctl && wr_data[6]) for (int i = 0; i < 7; i++) m_sh[i] = m_f[i];
        if (ctl && wr_data[1]) begin
          if (b2i(m_f[0]) >= 30) begin
            m_f[0] = 8'h00;
            m_min_carry();
          end else m_f[0] = 8'h00;
        end else if (tick && m_run) begin
          if (b2i(m_f[0]) >= 59) begin
            m_f[0] = 8'h00;
            m_min_carry();
          end else m_f[0] = i2b(b2i(m_f[0]) + 1);
        end
        if (ctl) begin
          m_run = wr_data[0]; m_12 = wr_data[3]; m_sel = wr_data[7];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (primed) begin
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL R10 model compare addr-prev read: actual %02h expected %02h at %0t",
                 rd_data, exp_rd, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, expv);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [7:0] expv, string tag);
    @(negedge clk); addr = a;
    @(negedge clk); check(tag, rd_data, expv);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d, logic tk = 1'b0);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1; tick = tk;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d,
                      logic [7:0] mo, logic [7:0] y, logic [7:0] w, logic m12);
    wr(5'h08, {4'b0, m12, 3'b000});
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, d);
    wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
    wr(5'h08, {4'b0, m12, 3'b001});
  endtask

  task automatic rd_date(logic [7:0] h, logic [7:0] d, logic [7:0] mo, logic [7:0] y, string tag);
    rd(5'h02, h, tag); rd(5'h03, d, tag); rd(5'h04, mo, tag); rd(5'h05, y, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, 8'h00, "R1 sec"); rd(5'h01, 8'h00, "R1 min"); rd(5'h02, 8'h00, "R1 hour");
    rd(5'h03, 8'h01, "R1 day"); rd(5'h04, 8'h01, "R1 month"); rd(5'h05, 8'h00, "R1 year");
    rd(5'h06, 8'h00, "R1 wday"); rd(5'h08, 8'h00, "R1 ctrl"); rd(5'h09, 8'h00, "R1 status");
    rd(5'h0A, 8'h00, "R10 unused address");

    // R4 ticks ignored while stopped
    ticks(3);
    rd(5'h00, 8'h00, "R4 stopped seconds");
    rd(5'h09, 8'h00, "R4 status stopped");

    // R2 / R3 full rollover to the new century
    load(8'h58, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06, 1'b0);
    rd(5'h09, 8'h02, "R4 status running");
    rd(5'h08, 8'h01, "R10 ctrl readback");
    ticks(3);
    rd(5'h00, 8'h01, "R2 sec after wrap"); rd(5'h01, 8'h00, "R2 min wrap");
    rd_date(8'h00, 8'h01, 8'h01, 8'h00, "R3 year-end rollover");
    rd(5'h06, 8'h00, "R3 weekday wrap");

    // R3 month lengths
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h02, 1'b0); ticks(1);
    rd_date(8'h00, 8'h29, 8'h02, 8'h24, "R3 leap Feb 29");
    rd(5'h06, 8'h03, "R3 weekday step");
    load(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h02, 1'b0); ticks(1);
    rd_date(8'h00, 8'h01, 8'h03, 8'h24, "R3 leap Feb end");
    load(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h02, 1'b0); ticks(1);
    rd_date(8'h00, 8'h01, 8'h03, 8'h23, "R3 common Feb end");
    load(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h25, 8'h02, 1'b0); ticks(1);
    rd_date(8'h00, 8'h01, 8'h05, 8'h25, "R3 30-day month");

    // R5 write drops tick in same cycle
    wr(5'h00, 8'h10, 1'b1);
    rd(5'h00, 8'h10, "R5 load wins over tick");

    // R6 / R7 snapshot and shadow select
    load(8'h20, 8'h05, 8'h07, 8'h10, 8'h06, 8'h30, 8'h01, 1'b0);
    ticks(2);
    wr(5'h08, 8'h41);
    ticks(3);
    rd(5'h08, 8'h01, "R6 snap bit reads 0");
    wr(5'h08, 8'h81);
    rd(5'h00, 8'h22, "R7 shadow seconds");
    rd(5'h01, 8'h05, "R7 shadow minutes");
    wr(5'h08, 8'h01);
    rd(5'h00, 8'h25, "R7 live seconds");

    // R8 12-hour mode
    load(8'h59, 8'h59, 8'h91, 8'h15, 8'h06, 8'h30, 8'h02, 1'b1); ticks(1);
    rd(5'h02, 8'h12, "R8 11PM to 12AM");
    rd(5'h03, 8'h16, "R8 day carry");
    rd(5'h08, 8'h09, "R8 ctrl mode readback");
    load(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h30, 8'h02, 1'b1); ticks(1);
    rd(5'h02, 8'h92, "R8 11AM to 12PM");
    rd(5'h03, 8'h15, "R8 no day carry");
    load(8'h59, 8'h59, 8'h92, 8'h15, 8'h06, 8'h30, 8'h02, 1'b1); ticks(1);
    rd(5'h02, 8'h81, "R8 12PM to 1PM");
    wr(5'h08, 8'h01);

    // R9 rounding
    load(8'h45, 8'h10, 8'h05, 8'h10, 8'h06, 8'h30, 8'h01, 1'b0);
    wr(5'h08, 8'h03, 1'b1);
    rd(5'h00, 8'h00, "R9 round up seconds");
    rd(5'h01, 8'h11, "R9 round up minute");
    rd(5'h08, 8'h01, "R9 round bit reads 0");
    load(8'h20, 8'h10, 8'h05, 8'h10, 8'h06, 8'h30, 8'h01, 1'b0);
    wr(5'h08, 8'h03);
    rd(5'h00, 8'h00, "R9 round down seconds");
    rd(5'h01, 8'h10, "R9 round down minute");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule